// File: doc/BRIEF.md
# SPI Receive Descriptor Ring Engine

This block sits behind an SPI shift stage and moves each received character into memory. Buffers are described by a ring of 8-byte descriptors that software prepares in memory. Ownership of each descriptor passes between the engine and the host through an Empty flag in the descriptor's status word. The engine fetches the descriptor at its current ring position and waits until the host has handed it over. It then stores incoming bytes through the descriptor's buffer pointer. A buffer is closed once it reaches the configured maximum length, or early when slave select is released. On close the engine writes back the byte count and the status, and may raise an event. It then moves to the next descriptor.

The ring has no fixed size. A Wrap flag in a descriptor sends the engine back to the ring base after that buffer. The memory port is a single synchronous port with 16-bit data and byte addresses. Read data returns in the cycle after the request, and halfwords are big-endian. Characters that arrive while the engine cannot store them are dropped, and the next buffer it closes is marked as overrun.

Top module: `spi_rx_ring_dma`

## Requirements
- R1: While `rst_n` is low or `en` is low, no memory request is issued. After reset `evt` is 0 and `irq` is 0. Once enabled, the first descriptor is fetched at `ring_base`.
- R2: A descriptor is read as a status halfword at offset 0 and a buffer pointer whose upper halfword is at offset 4 and lower halfword at offset 6. Bytes are stored only if status bit 15 (Empty) is 1. Otherwise the status is read again and nothing is written.
- R3: The n-th byte of a buffer (counting from 0) is written to byte address pointer+n. An even address uses the upper lane (`mem_be`=2'b10, data in bits 15:8). An odd address uses the lower lane (`mem_be`=2'b01, data in bits 7:0).
- R4: When the byte count reaches `max_len`, the buffer is closed and the count is written as a full halfword at descriptor offset 2.
- R5: If `ss_n` is high while the current buffer holds at least one byte, that buffer is closed at once with its partial count. Its written-back status has bit 11 (Last) set.
- R6: The status written back on close has these bits:
  - bit 15 (Empty) = 0 and bit 14 = 0.
  - bits 13 (Wrap), 12 (Interrupt) and 9 (Continuous) copied from the fetched status.
  - bit 11 (Last) as in R5.
  - bit 1 (Overrun) as in R10.
  - bit 0 and all other bits = 0.
- R7: After a closed descriptor whose status bit 13 is set, the next fetch is at `ring_base`. Otherwise it is at the descriptor address plus 8.
- R8: Closing a buffer whose status bit 12 is set sets `evt[0]`. With bit 12 clear, `evt[0]` is not set.
- R9: A descriptor with an odd buffer pointer receives no byte. It is closed with length 0 and status as in R6, and `evt[1]` is set.
- R10: A character presented on `rx_valid` while no owned buffer is open is dropped and not written. The next status written back then has bit 1 (Overrun) set.
- R11: Each `evt` bit stays set until a cycle with the matching `evt_clr` bit high. `irq` is high exactly when some `evt` bit is set and its `evt_mask` bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Engine enable; low returns to the ring base |
| ring_base | input | AW | Byte address of the first descriptor (8-aligned) |
| max_len | input | 16 | Maximum bytes per receive buffer (at least 1) |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| ss_n | input | 1 | Slave select, active low |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Byte address |
| mem_be | output | 2 | Byte lane enables, bit 1 = upper lane |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| evt_mask | input | 2 | Interrupt mask per event bit |
| evt_clr | input | 2 | Write-one-to-clear strobes for event bits |
| evt | output | 2 | Sticky events: bit 0 buffer closed, bit 1 odd pointer |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume the following about the inputs:
- `ring_base` is 8-aligned, so that offsets 0 and 2 in the address identify status and length writes.
- `max_len` is at least 1 and is held steady while the engine runs.
- `rx_data` arrives only as isolated one-cycle strobes.

The stimulus follows these limits. It programs the registers once before enabling the engine and never changes them. It spaces characters several cycles apart and allows time for each descriptor fetch to finish. Characters are sent while nothing is owned only in the overrun case, where dropping them is the intended outcome.

// File: rtl/spi_rxr_pkg.sv
package spi_rxr_pkg;
    // status bit positions (bit 15 is the most significant, first on the wire)
    localparam int ST_EMPTY = 15;
    localparam int ST_RSVD  = 14;
    localparam int ST_WRAP  = 13;
    localparam int ST_INTR  = 12;
    localparam int ST_LAST  = 11;
    localparam int ST_CONT  = 9;
    localparam int ST_OVR   = 1;
    localparam int ST_MERR  = 0;

    // descriptor layout in bytes
    localparam int DESC_SIZE = 8;
    localparam int OFF_LEN   = 2;
    localparam int OFF_PHI   = 4;
    localparam int OFF_PLO   = 6;

    // event bit indices
    localparam int EV_RXB  = 0;
    localparam int EV_PERR = 1;
    localparam int EV_N    = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RDST,
        S_CKST,
        S_RDPH,
        S_RDPL,
        S_CKPL,
        S_RECV,
        S_WLEN,
        S_WST
    } rxr_state_e;
endpackage

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
    import spi_rxr_pkg::*;
(
    input  logic [15:0] fetched,
    input  logic        last,
    input  logic        ovr,
    output logic [15:0] closed
);
    always_comb begin
        closed           = '0;
        closed[ST_WRAP]  = fetched[ST_WRAP];
        closed[ST_INTR]  = fetched[ST_INTR];
        closed[ST_CONT]  = fetched[ST_CONT];
        closed[ST_LAST]  = last;
        closed[ST_OVR]   = ovr;
        closed[ST_MERR]  = 1'b0;
        closed[ST_EMPTY] = 1'b0;
        closed[ST_RSVD]  = 1'b0;
    end
endmodule

// File: rtl/rxr_event.sv
module rxr_event #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] evt,
    output logic         irq
);
    logic [N-1:0] evt_d, evt_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            evt_d[i] = set[i] | (evt_q[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    assign evt = evt_q;
    assign irq = |(evt_q & mask);
endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
    import spi_rxr_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] ring_base,
    input  logic [LW-1:0] max_len,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          ss_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic [15:0]   fmt_fetched,
    output logic          fmt_last,
    output logic          fmt_ovr,
    input  logic [15:0]   fmt_closed,
    output logic [EV_N-1:0] ev_set
);
    localparam int PW = 32;

    typedef struct packed {
        rxr_state_e    st;
        logic [AW-1:0] desc;
        logic [PW-1:0] ptr;
        logic [15:0]   stat;
        logic [LW-1:0] cnt;
        logic          last;
        logic          ovr;
        logic          perr;
    } rxr_regs_t;

    rxr_regs_t q, d;
    logic [AW-1:0] byte_addr;
    logic [LW:0]   cnt_nx;

    assign byte_addr   = q.ptr[AW-1:0] + AW'(q.cnt);
    assign cnt_nx      = {1'b0, q.cnt} + 1'b1;
    assign fmt_fetched = q.stat;
    assign fmt_last    = q.last;
    assign fmt_ovr     = q.ovr;

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.desc;
        mem_be    = 2'b11;
        mem_wdata = '0;
        ev_set    = '0;

        // characters that cannot be stored are dropped and remembered
        if (rx_valid && q.st != S_RECV) d.ovr = 1'b1;

        unique case (q.st)
            S_IDLE: begin
                d.desc = ring_base;
                if (en) d.st = S_RDST;
            end
            S_RDST: begin
                mem_req = 1'b1;
                d.st    = S_CKST;
            end
            S_CKST: begin
                d.stat = mem_rdata;
                d.st   = mem_rdata[ST_EMPTY] ? S_RDPH : S_RDST;
            end
            S_RDPH: begin
                mem_req  = 1'b1;
                mem_addr = q.desc + AW'(OFF_PHI);
                d.st     = S_RDPL;
            end
            S_RDPL: begin
                mem_req  = 1'b1;
                mem_addr = q.desc + AW'(OFF_PLO);
                d.ptr    = {mem_rdata, 16'h0000};
                d.st     = S_CKPL;
            end
            S_CKPL: begin
                d.ptr[15:0] = mem_rdata;
                d.cnt       = '0;
                d.last      = 1'b0;
                if (mem_rdata[0]) begin
                    d.perr = 1'b1;
                    d.st   = S_WLEN;
                end else begin
                    d.st   = S_RECV;
                end
            end
            S_RECV: begin
                if (rx_valid) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = byte_addr;
                    mem_be    = byte_addr[0] ? 2'b01 : 2'b10;
                    mem_wdata = {rx_data, rx_data};
                    d.cnt     = cnt_nx[LW-1:0];
                    if (cnt_nx >= {1'b0, max_len}) d.st = S_WLEN;
                end else if (ss_n && q.cnt != '0) begin
                    d.last = 1'b1;
                    d.st   = S_WLEN;
                end
            end
            S_WLEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.desc + AW'(OFF_LEN);
                mem_wdata = 16'(q.cnt);
                d.st      = S_WST;
            end
            S_WST: begin
                mem_req          = 1'b1;
                mem_we           = 1'b1;
                mem_wdata        = fmt_closed;
                ev_set[EV_RXB]   = q.stat[ST_INTR];
                ev_set[EV_PERR]  = q.perr;
                d.ovr            = rx_valid;
                d.perr           = 1'b0;
                d.desc           = q.stat[ST_WRAP] ? ring_base : q.desc + AW'(DESC_SIZE);
                d.st             = S_RDST;
            end
            default: d.st = S_IDLE;
        endcase

        if (!en) begin
            d.st   = S_IDLE;
            d.desc = ring_base;
            d.ovr  = 1'b0;
            d.perr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.desc <= '0;
            q.ptr  <= '0;
            q.stat <= '0;
            q.cnt  <= '0;
            q.last <= 1'b0;
            q.ovr  <= 1'b0;
            q.perr <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/spi_rx_ring_dma.sv
module spi_rx_ring_dma
    import spi_rxr_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] ring_base,
    input  logic [LW-1:0] max_len,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          ss_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_be,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    input  logic [1:0]    evt_mask,
    input  logic [1:0]    evt_clr,
    output logic [1:0]    evt,
    output logic          irq
);
    logic [15:0]     fetched, closed;
    logic            last, ovr;
    logic [EV_N-1:0] ev_set;

    rxr_fsm #(.AW(AW), .LW(LW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .ring_base  (ring_base),
        .max_len    (max_len),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .ss_n       (ss_n),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .fmt_fetched(fetched),
        .fmt_last   (last),
        .fmt_ovr    (ovr),
        .fmt_closed (closed),
        .ev_set     (ev_set)
    );

    rxr_status_fmt u_fmt (
        .fetched(fetched),
        .last   (last),
        .ovr    (ovr),
        .closed (closed)
    );

    rxr_event #(.N(EV_N)) u_evt (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ev_set),
        .clr  (evt_clr),
        .mask (evt_mask),
        .evt  (evt),
        .irq  (irq)
    );
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [LW-1:0] max_len,
    input logic          rx_valid,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_be,
    input logic [15:0]   mem_wdata,
    input logic [1:0]    evt,
    input logic [1:0]    evt_clr
);
    // R1
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mem_req);

    // R6
    stat_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 2'b11 && mem_addr[2:0] == 3'd0)
        |-> (mem_wdata[15:14] == 2'b00));

    // R4
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 2'b11 && mem_addr[2:0] == 3'd2)
        |-> (mem_wdata <= 16'(max_len)));

    // R3
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $countones(mem_be) == 1)
        |-> (rx_valid && mem_be[1] == !mem_addr[0]));

    // R8
    rxb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt[0]) |-> $past(mem_req && mem_we && mem_be == 2'b11
                                && mem_addr[2:0] == 3'd0 && mem_wdata[12]));

    // R11
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[0] && !evt_clr[0]) |=> evt[0]);
endmodule

bind spi_rx_ring_dma rxr_chk #(.AW(AW), .LW(LW)) u_rxr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .max_len  (max_len),
    .rx_valid (rx_valid),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_wdata(mem_wdata),
    .evt      (evt),
    .evt_clr  (evt_clr)
);

// File: tb/tb_spi_rx_ring_dma.sv
module tb_spi_rx_ring_dma;
    localparam int AW = 32;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic [LW-1:0] max_len = 16'd4;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          ss_n = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_be;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic [1:0]    evt_mask = 2'b11;
    logic [1:0]    evt_clr = 2'b00;
    logic [1:0]    evt;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] mem [0:255];

    always #10 clk = ~clk;

    spi_rx_ring_dma #(.AW(AW), .LW(LW)) dut (.*);

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[8:1]];
        if (mem_req && mem_we) begin
            if (mem_be[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
            if (mem_be[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        wait_n(4);
    endtask

    task automatic clear_evt(input logic [1:0] m);
        @(negedge clk);
        evt_clr = m;
        @(negedge clk);
        evt_clr = 2'b00;
    endtask

    task automatic t_reset;
        wait_n(3);
        chk("R1 mem_req in reset", {15'd0, mem_req}, 16'd0);
        chk("R1 evt after reset", {14'd0, evt}, 16'd0);
        chk("R1 irq after reset", {15'd0, irq}, 16'd0);
        rst_n = 1'b1;
        wait_n(3);
        chk("R1 mem_req while disabled", {15'd0, mem_req}, 16'd0);
        en = 1'b1;
        wait_n(12);
    endtask

    task automatic t_full;
        send(8'hAA); send(8'hBB); send(8'hCC); send(8'hDD);
        wait_n(10);
        chk("R3 bytes 0/1", mem[8'h80], 16'hAABB);
        chk("R3 bytes 2/3", mem[8'h81], 16'hCCDD);
        chk("R4 length full", mem[1], 16'd4);
        chk("R6 status full close", mem[0], 16'h1200);
        chk("R8 evt rxb set", {14'd0, evt}, 16'd1);
        chk("R11 irq when unmasked", {15'd0, irq}, 16'd1);
        clear_evt(2'b01);
        chk("R11 evt cleared", {14'd0, evt}, 16'd0);
        chk("R11 irq after clear", {15'd0, irq}, 16'd0);
        wait_n(8);
    endtask

    task automatic t_ss_close;
        send(8'h11); send(8'h22); send(8'h33);
        @(negedge clk); ss_n = 1'b1;
        wait_n(3);
        @(negedge clk); ss_n = 1'b0;
        wait_n(10);
        chk("R5 partial length", mem[5], 16'd3);
        chk("R5 status Last", mem[4], 16'h0800);
        chk("R3 odd tail byte", mem[8'h91], 16'h3300);
        chk("R8 no event for I=0", {14'd0, evt}, 16'd0);
    endtask

    task automatic t_owner_overrun;
        send(8'hE1); send(8'hE2);
        wait_n(6);
        chk("R2 unowned buffer untouched", mem[8'hA0], 16'h0000);
        chk("R10 drop leaves status", mem[8], 16'h3000);
        chk("R10 drop raises no event", {14'd0, evt}, 16'd0);
        @(negedge clk); mem[8] = 16'hB000;
        wait_n(12);
        send(8'h01); send(8'h02); send(8'h03); send(8'h04);
        wait_n(10);
        chk("R2 owned buffer data", mem[8'hA0], 16'h0102);
        chk("R2 owned buffer data hi", mem[8'hA1], 16'h0304);
        chk("R10 overrun status", mem[8], 16'h3002);
        chk("R4 length after overrun", mem[9], 16'd4);
        chk("R8 evt rxb", {14'd0, evt}, 16'd1);
        clear_evt(2'b01);
    endtask

    task automatic t_wrap_odd;
        @(negedge clk);
        mem[2] = 16'h0000;
        mem[3] = 16'h0161;
        mem[0] = 16'h8000;
        wait_n(14);
        chk("R7 wrap reused ring base", mem[0], 16'h0000);
        chk("R7 no fetch past wrap", mem[12], 16'h0000);
        chk("R9 odd length zero", mem[1], 16'd0);
        chk("R9 odd buffer untouched", mem[8'hB0], 16'h0000);
        chk("R9 perr event", {14'd0, evt}, 16'd2);
        chk("R11 irq perr unmasked", {15'd0, irq}, 16'd1);
        @(negedge clk); evt_mask = 2'b01;
        @(negedge clk);
        chk("R11 irq masked", {15'd0, irq}, 16'd0);
        chk("R11 evt kept while masked", {14'd0, evt}, 16'd2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[0] = 16'hD200; mem[2] = 16'h0000; mem[3] = 16'h0100;
        mem[4] = 16'h8000; mem[6] = 16'h0000; mem[7] = 16'h0120;
        mem[8] = 16'h3000; mem[10] = 16'h0000; mem[11] = 16'h0140;
        t_reset();
        t_full();
        t_ss_close();
        t_owner_overrun();
        t_wrap_odd();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule